// File: doc/BRIEF.md
# LCD Panel Scan Timing Generator

This block produces the scan timing for a parallel LCD panel: horizontal sync, vertical sync, a data-enable, a pixel clock and a one-cycle pixel-clock-enable. Three 32-bit configuration words set the timing. The horizontal word and the vertical word share one field layout. The clock word holds a pixel clock divider and four polarity inversion bits. A run input starts and stops the scan.

Each line runs through four segments measured in pixel steps, in this order: sync, leading porch, active pixels, trailing porch. Each frame runs through the same four segments measured in lines. The block exposes its position within the line and within the frame, an active-video flag, and one-cycle strobes that mark the last pixel of a line and the last pixel of a frame. Downstream pixel fetch logic uses these outputs to pace itself.

Top module: `lcd_scan_timer`

## Requirements
- R1: Horizontal word fields are stored as count minus one: active pixels in bits [9:0], sync width in [15:10], leading porch in [23:16] and trailing porch in [31:24]. Within a line, horizontal sync (before inversion) is high for the first sync-width pixel steps, and active pixels begin after the leading porch.
- R2: A line lasts exactly sync + leading porch + active + trailing porch pixel steps. `lineEnd` is high for one clock, on the pixel step of the line's last position, and on no other cycle.
- R3: The vertical word uses the R1 layout and the same segment order, counted in lines. Vertical sync is high (before inversion) during the first sync-width lines. `frameEnd` is high only on the `lineEnd` step of the frame's last line, and both position counters then return to 0.
- R4: The divider field occupies clock word bits [9:0] and holds the raw divider D, with no minus-one offset. `pixClkEn` pulses exactly once every 2×(D+1) clocks. The pixel clock output (before inversion) is high for D+1 clocks of each period, and positions change only on `pixClkEn`.
- R5: Clock word bit 15 inverts vertical sync, bit 16 inverts horizontal sync, bit 17 inverts the pixel clock and bit 18 inverts the data-enable. Each bit affects only its own output.
- R6: `activeVideo`, and the data-enable before inversion, are high exactly when both the horizontal and the vertical positions lie in their active segments.
- R7: The active segment is capped at 800 pixels per line and 600 lines per frame. A larger field value counts as the cap.
- R8: While run is low, `pixClkEn`, `lineEnd`, `frameEnd` and `activeVideo` are low, every panel output sits at its inactive level (equal to its inversion bit), and both counters are 0 from the next clock on. After run rises, scanning restarts at pixel 0 of line 0.
- R9: `pixelPos` gives the position within the line, and `linePos` gives the line within the frame. Both count from 0, starting at the sync segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Scan run control |
| hTimingCfg | input | 32 | Horizontal timing word |
| vTimingCfg | input | 32 | Vertical timing word |
| clkCtrlCfg | input | 32 | Divider and polarity word |
| pixClkEn | output | 1 | One-clock pixel step enable |
| pixClkOut | output | 1 | Panel pixel clock after polarity |
| hSyncOut | output | 1 | Horizontal sync after polarity |
| vSyncOut | output | 1 | Vertical sync after polarity |
| dataEnOut | output | 1 | Data-enable after polarity |
| activeVideo | output | 1 | High during visible pixels |
| lineEnd | output | 1 | Strobe on the last pixel step of a line |
| frameEnd | output | 1 | Strobe on the last pixel step of a frame |
| pixelPos | output | 11 | Position within the line |
| linePos | output | 11 | Line within the frame |

## Verification
The bound checker checks a set of rules on every clock:
- the idle quietness and idle output levels while stopped;
- strobe nesting (a frame end always falls on a line end, and a line end always falls on a pixel step);
- counter stepping and holding between enables;
- the return to origin after a frame end;
- the exclusion of sync during active video.

Some properties depend on the configured field values, so only the directed scenarios can show them: the exact segment boundaries, the line and frame lengths, the divider period, the per-signal effect of each inversion bit, and the caps at 800 and 600.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int ACT_W   = 10;
  localparam int SYNC_W  = 6;
  localparam int PORCH_W = 8;
  localparam int DIV_W   = 10;
  // widest line or frame: largest sync + two largest porches + largest active
  localparam int POS_W = $clog2((1 << SYNC_W) + 2 * (1 << PORCH_W) + (1 << ACT_W));

  // bit positions decoded from the clock word
  localparam int INV_VS_BIT = 15;
  localparam int INV_HS_BIT = 16;
  localparam int INV_PC_BIT = 17;
  localparam int INV_DE_BIT = 18;

  typedef struct packed {
    logic clear;
    logic pixStep;
    logic lineWrap;
    logic frameWrap;
  } scan_strobe_t;
endpackage

// File: rtl/lcd_scan_axis.sv
module lcd_scan_axis
  import lcd_scan_pkg::*;
#(
  parameter int MAX_ACTIVE = 800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             step,
  input  logic [31:0]      cfg,
  output logic [POS_W-1:0] pos,
  output logic             inSync,
  output logic             inActive,
  output logic             atLast
);
  localparam logic [POS_W-1:0] ACT_CAP = POS_W'(MAX_ACTIVE);
  localparam logic [POS_W-1:0] ONE     = POS_W'(1);

  logic [POS_W-1:0] syncLen, leadLen, actRaw, actLen, trailLen;
  logic [POS_W-1:0] actStart, actEnd, total;

  always_comb begin
    syncLen  = POS_W'(cfg[15:10]) + ONE;
    leadLen  = POS_W'(cfg[23:16]) + ONE;
    actRaw   = POS_W'(cfg[9:0]) + ONE;
    trailLen = POS_W'(cfg[31:24]) + ONE;
    actLen   = (actRaw > ACT_CAP) ? ACT_CAP : actRaw;
    actStart = syncLen + leadLen;
    actEnd   = actStart + actLen;
    total    = actEnd + trailLen;
  end

  assign atLast   = (pos >= total - ONE);
  assign inSync   = (pos < syncLen);
  assign inActive = (pos >= actStart) && (pos < actEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pos <= '0;
    else if (clear)  pos <= '0;
    else if (step)   pos <= atLast ? '0 : pos + ONE;
  end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divCfg,
  input  logic             hLast,
  input  logic             vLast,
  output scan_strobe_t     strobe,
  output logic             pixClkRaw
);
  logic [DIV_W-1:0] divCnt;
  logic             phase;
  logic             divWrap;

  assign divWrap = (divCnt >= divCfg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (!run) begin
      divCnt <= '0;
      phase  <= 1'b0;
    end else if (divWrap) begin
      divCnt <= '0;
      phase  <= ~phase;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strobe.clear     = ~run;
    strobe.pixStep   = run & divWrap & phase;
    strobe.lineWrap  = strobe.pixStep & hLast;
    strobe.frameWrap = strobe.lineWrap & vLast;
  end

  assign pixClkRaw = phase;
endmodule

// File: rtl/lcd_scan_datapath.sv
module lcd_scan_datapath
  import lcd_scan_pkg::*;
#(
  parameter int MAX_PIXELS = 800,
  parameter int MAX_LINES  = 600
) (
  input  logic             clk,
  input  logic             rstN,
  input  scan_strobe_t     strobe,
  input  logic             run,
  input  logic [31:0]      hCfg,
  input  logic [31:0]      vCfg,
  input  logic [3:0]       invBits,
  input  logic             pixClkRaw,
  output logic             hLast,
  output logic             vLast,
  output logic [POS_W-1:0] pixelPos,
  output logic [POS_W-1:0] linePos,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             dataEnOut,
  output logic             pixClkOut,
  output logic             activeVideo
);
  logic [1:0][31:0]      axisCfg;
  logic [1:0]            axisStep, axisSync, axisAct, axisLast;
  logic [1:0][POS_W-1:0] axisPos;
  logic                  unusedStrobe;

  assign axisCfg[0]   = hCfg;
  assign axisCfg[1]   = vCfg;
  assign axisStep     = {strobe.lineWrap, strobe.pixStep};
  assign unusedStrobe = strobe.frameWrap;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    localparam int CAP = (g == 0) ? MAX_PIXELS : MAX_LINES;
    lcd_scan_axis #(.MAX_ACTIVE(CAP)) u_axis (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (strobe.clear),
      .step     (axisStep[g]),
      .cfg      (axisCfg[g]),
      .pos      (axisPos[g]),
      .inSync   (axisSync[g]),
      .inActive (axisAct[g]),
      .atLast   (axisLast[g])
    );
  end

  assign hLast    = axisLast[0];
  assign vLast    = axisLast[1];
  assign pixelPos = axisPos[0];
  assign linePos  = axisPos[1];

  // invBits: [0] vsync, [1] hsync, [2] pixel clock, [3] data enable
  assign activeVideo = run & axisAct[0] & axisAct[1];
  assign hSyncOut    = (run & axisSync[0]) ^ invBits[1];
  assign vSyncOut    = (run & axisSync[1]) ^ invBits[0];
  assign dataEnOut   = activeVideo ^ invBits[3];
  assign pixClkOut   = pixClkRaw ^ invBits[2];
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int MAX_PIXELS = 800,
  parameter int MAX_LINES  = 600
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [31:0]      hTimingCfg,
  input  logic [31:0]      vTimingCfg,
  input  logic [31:0]      clkCtrlCfg,
  output logic             pixClkEn,
  output logic             pixClkOut,
  output logic             hSyncOut,
  output logic             vSyncOut,
  output logic             dataEnOut,
  output logic             activeVideo,
  output logic             lineEnd,
  output logic             frameEnd,
  output logic [POS_W-1:0] pixelPos,
  output logic [POS_W-1:0] linePos
);
  scan_strobe_t strobe;
  logic         hLast, vLast, pixClkRaw;
  logic [3:0]   invBits;
  logic         unusedCfgBits;

  assign invBits       = {clkCtrlCfg[INV_DE_BIT], clkCtrlCfg[INV_PC_BIT],
                          clkCtrlCfg[INV_HS_BIT], clkCtrlCfg[INV_VS_BIT]};
  assign unusedCfgBits = ^{clkCtrlCfg[31:19], clkCtrlCfg[14:DIV_W]};

  lcd_scan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (runEn),
    .divCfg    (clkCtrlCfg[DIV_W-1:0]),
    .hLast     (hLast),
    .vLast     (vLast),
    .strobe    (strobe),
    .pixClkRaw (pixClkRaw)
  );

  lcd_scan_datapath #(.MAX_PIXELS(MAX_PIXELS), .MAX_LINES(MAX_LINES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .run         (runEn),
    .hCfg        (hTimingCfg),
    .vCfg        (vTimingCfg),
    .invBits     (invBits),
    .pixClkRaw   (pixClkRaw),
    .hLast       (hLast),
    .vLast       (vLast),
    .pixelPos    (pixelPos),
    .linePos     (linePos),
    .hSyncOut    (hSyncOut),
    .vSyncOut    (vSyncOut),
    .dataEnOut   (dataEnOut),
    .pixClkOut   (pixClkOut),
    .activeVideo (activeVideo)
  );

  assign pixClkEn = strobe.pixStep;
  assign lineEnd  = strobe.lineWrap;
  assign frameEnd = strobe.frameWrap;
endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker
  import lcd_scan_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic [3:0]       invBits,
  input logic             pixClkEn,
  input logic             hSyncOut,
  input logic             vSyncOut,
  input logic             dataEnOut,
  input logic             activeVideo,
  input logic             lineEnd,
  input logic             frameEnd,
  input logic [POS_W-1:0] pixelPos,
  input logic [POS_W-1:0] linePos
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (!pixClkEn && !lineEnd && !frameEnd && !activeVideo)); // R8
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (hSyncOut == invBits[1] && vSyncOut == invBits[0] && dataEnOut == invBits[3])); // R5
  AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (pixelPos == '0 && linePos == '0)); // R8
  AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> lineEnd); // R3
  AST_LINE_ON_STEP: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |-> pixClkEn); // R2
  AST_PIX_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && pixClkEn && !lineEnd) |=> (pixelPos == $past(pixelPos) + POS_W'(1))); // R9
  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !pixClkEn) |=> $stable(pixelPos)); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !lineEnd) |=> $stable(linePos)); // R3
  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (pixelPos == '0 && linePos == '0)); // R3
  AST_NO_SYNC_IN_VIDEO: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> (hSyncOut == invBits[1])); // R6
endmodule

bind lcd_scan_timer lcd_scan_checker u_scan_checker (
  .clk         (clk),
  .rstN        (rstN),
  .runEn       (runEn),
  .invBits     (invBits),
  .pixClkEn    (pixClkEn),
  .hSyncOut    (hSyncOut),
  .vSyncOut    (vSyncOut),
  .dataEnOut   (dataEnOut),
  .activeVideo (activeVideo),
  .lineEnd     (lineEnd),
  .frameEnd    (frameEnd),
  .pixelPos    (pixelPos),
  .linePos     (linePos)
);

// File: tb/lcd_scan_timer_bench.sv
module lcd_scan_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [31:0] hTimingCfg = '0, vTimingCfg = '0, clkCtrlCfg = '0;
  logic        pixClkEn, pixClkOut, hSyncOut, vSyncOut, dataEnOut, activeVideo, lineEnd, frameEnd;
  logic [10:0] pixelPos, linePos;

  int checks = 0, failures = 0, cycles = 0;
  int hS, hP1, hA, hP2, vS, vP1, vA, vP2, divVal;
  logic [3:0] inv; // [0] vsync bit15, [1] hsync bit16, [2] pclk bit17, [3] de bit18

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcd_scan_timer u_lcd_scan_timer (
    .clk(clk), .rstN(rstN), .runEn(runEn), .hTimingCfg(hTimingCfg), .vTimingCfg(vTimingCfg),
    .clkCtrlCfg(clkCtrlCfg), .pixClkEn(pixClkEn), .pixClkOut(pixClkOut), .hSyncOut(hSyncOut),
    .vSyncOut(vSyncOut), .dataEnOut(dataEnOut), .activeVideo(activeVideo), .lineEnd(lineEnd),
    .frameEnd(frameEnd), .pixelPos(pixelPos), .linePos(linePos)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] packWord(input int act, input int sync, input int lead, input int trail);
    return {8'(trail - 1), 8'(lead - 1), 6'(sync - 1), 10'(act - 1)};
  endfunction

  task automatic setup_run(input int h0, input int h1, input int h2, input int h3,
                           input int v0, input int v1, input int v2, input int v3,
                           input int d, input logic [3:0] iv);
    @(negedge clk);
    runEn = 1'b0;
    hS = h0; hP1 = h1; hA = h2; hP2 = h3; vS = v0; vP1 = v1; vA = v2; vP2 = v3;
    divVal = d; inv = iv;
    hTimingCfg = packWord(hA, hS, hP1, hP2);
    vTimingCfg = packWord(vA, vS, vP1, vP2);
    clkCtrlCfg = {13'd0, iv, 5'd0, 10'(d)};
    @(negedge clk);
    runEn = 1'b1;
  endtask

  task automatic check_idle(input string tag);
    chk("R8", {tag, " pixClkEn idle"}, int'(pixClkEn), 0);
    chk("R8", {tag, " strobes idle"}, int'(lineEnd | frameEnd | activeVideo), 0);
    chk("R8", {tag, " counters zero"}, int'(pixelPos) + int'(linePos), 0);
    chk("R5", {tag, " idle levels"}, int'({dataEnOut, pixClkOut, hSyncOut, vSyncOut}), int'(inv));
  endtask

  // Observe one complete frame from the step after a frameEnd to the next frameEnd.
  task automatic run_frame(input string tag);
    int hAe, vAe, hTot, vTot, period, pos, ln, steps, gap, clkHi, n, actSteps;
    int badPos, badHs, badVs, badDe, badLe, badFe, badGap;
    bit expHs, expVs, expDe, expLe, expFe;
    hAe = (hA > 800) ? 800 : hA;
    vAe = (vA > 600) ? 600 : vA;
    hTot = hS + hP1 + hAe + hP2;
    vTot = vS + vP1 + vAe + vP2;
    period = 2 * (divVal + 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!(pixClkEn && frameEnd) && n < 40000);
    chk("R3", {tag, " frame end seen"}, int'(n < 40000), 1);
    pos = 0; ln = 0; steps = 0; gap = 0; clkHi = 0; actSteps = 0;
    badPos = 0; badHs = 0; badVs = 0; badDe = 0; badLe = 0; badFe = 0; badGap = 0;
    forever begin
      @(negedge clk);
      gap++;
      if (pixClkOut ^ inv[2]) clkHi++;
      if (pixClkEn) begin
        steps++;
        if (gap != period) badGap++;
        gap = 0;
        expHs = pos < hS;
        expVs = ln < vS;
        expDe = (pos >= hS + hP1) && (pos < hS + hP1 + hAe) && (ln >= vS + vP1) && (ln < vS + vP1 + vAe);
        expLe = (pos == hTot - 1);
        expFe = expLe && (ln == vTot - 1);
        if (int'(pixelPos) != pos || int'(linePos) != ln) badPos++;
        if ((hSyncOut ^ inv[1]) != expHs) badHs++;
        if ((vSyncOut ^ inv[0]) != expVs) badVs++;
        if (activeVideo != expDe || (dataEnOut ^ inv[3]) != expDe) badDe++;
        if (lineEnd != expLe) badLe++;
        if (frameEnd != expFe) badFe++;
        if (activeVideo) actSteps++;
        if (frameEnd || steps > hTot * vTot + 4) break;
        if (expLe) begin pos = 0; ln++; end else pos++;
      end else if (lineEnd || frameEnd) begin
        badLe++;
      end
    end
    chk("R9", {tag, " position counters"}, badPos, 0);
    chk("R1", {tag, " hsync segment"}, badHs, 0);
    chk("R3", {tag, " vsync segment"}, badVs, 0);
    chk("R6", {tag, " data enable"}, badDe, 0);
    chk("R2", {tag, " lineEnd placement"}, badLe, 0);
    chk("R3", {tag, " frameEnd placement"}, badFe, 0);
    chk("R2", {tag, " steps per frame"}, steps, hTot * vTot);
    chk("R4", {tag, " step period"}, badGap, 0);
    chk("R4", {tag, " pixel clock high time"}, clkHi, steps * (divVal + 1));
    chk("R7", {tag, " active pixels per frame"}, actSteps, hAe * vAe);
  endtask

  task automatic t_reset();
    inv = 4'b0000;
    repeat (3) @(negedge clk);
    check_idle("reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("after reset");
  endtask

  task automatic t_basic();
    setup_run(2, 3, 4, 2, 1, 2, 3, 1, 0, 4'b0000);
    run_frame("basic R1");
  endtask

  task automatic t_divider();
    setup_run(1, 1, 2, 1, 2, 1, 2, 1, 3, 4'b0000);
    run_frame("divider R4");
  endtask

  task automatic t_polarity();
    setup_run(3, 1, 3, 1, 1, 1, 2, 2, 1, 4'b1111);
    run_frame("all inverted R5");
    setup_run(3, 1, 3, 1, 1, 1, 2, 2, 1, 4'b0110);
    run_frame("hsync+pclk inverted R5");
    runEn = 1'b0;
    @(negedge clk);
    check_idle("stopped inverted R5");
  endtask

  task automatic t_clamp();
    setup_run(1, 1, 1024, 1, 1, 1, 1, 1, 0, 4'b0000);
    run_frame("line cap R7");
    setup_run(1, 1, 1, 1, 1, 1, 1024, 1, 0, 4'b1000);
    run_frame("frame cap R7");
  endtask

  task automatic t_run_stop();
    int n;
    setup_run(2, 2, 3, 2, 2, 1, 2, 1, 0, 4'b0001);
    repeat (37) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check_idle("stop R8");
    repeat (10) @(negedge clk);
    check_idle("held stop R8");
    runEn = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!pixClkEn && n < 100);
    chk("R8", "restart at origin", int'(pixelPos) + int'(linePos), 0);
    chk("R8", "restart in sync", int'({hSyncOut ^ inv[1], vSyncOut ^ inv[0]}), 3);
    run_frame("after restart R8");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        failures++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_divider();
    t_polarity();
    t_clamp();
    t_run_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule